// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block brings a serially configured LCD panel from power-on to a running display without software help. A `start` pulse makes it drive the panel reset line through a timed high-low-high waveform. It then reads the panel's identification byte through an external serial word engine. The ID picks one of two configuration scripts held in an on-chip ROM. Each script step is sent to the engine as a 9-bit word: a command or a parameter, with optional millisecond pauses between steps. The run ends with a display-on command, a fixed pause and a wake command, after which `ready` rises.

The serial engine is outside this block. The block raises `xfer_req` with a word (or a read request) and holds it until the engine returns a one-cycle `xfer_done`, which may carry `xfer_err` and, for reads, `xfer_rdata`. All timing comes from a millisecond timer derived from the `CYCLES_PER_MS` parameter, so a test configuration can use a very short millisecond.

Top module: `lcd_boot_seq`

## Requirements
- R1: After reset and before any `start`, `panel_rst_n` is 0, `xfer_req` is 0, `ready` is 0, `fail` is 0 and `err_count` is 0.
- R2: After `start`, `panel_rst_n` is 1 for 100 ms, then 0 for 40 ms, then 1 for 100 ms before the first `xfer_req`. Each N ms interval lasts exactly N*CYCLES_PER_MS+1 clock cycles, and `xfer_req` is never high while `panel_rst_n` is 0.
- R3: The ID read is three transfers: a write of word 0x004, then two reads. The `xfer_rdata` of the second read is the panel ID.
- R4: An ID equal to `ID_FIRST` (default 0x80) selects script A. Its commands, in order, with parameter counts, are 0x36(1), 0x3A(1), 0xB6(4), 0xC5(2), 0xE0(16), 0xE1(16), 0xB0(1), 0xB4(1).
- R5: Any other ID selects script B: 0xFF with parameters 0xFF, 0x98, 0x06, then 0xBA(1), 0x36(1), 0x3A(1), and last 0x35(1).
- R6: Word bit 8 is 0 for a command and 1 for a parameter, and bits 7:0 carry the byte. Script A's first parameter is 0x08, so its word is 0x108.
- R7: In script A, the transfer after entry 0xE1 starts at least 20 ms after that entry ends, and the transfer after 0xB4 starts at least 100 ms after it. Every other entry is followed within 8 cycles. Each waited gap is under its delay plus 12 cycles.
- R8: After the script comes display-on 0x29, then at least 100 ms, then wake 0x11 (no parameters), and then no more transfers. `ready` then rises and stays high until the next `start`.
- R9: While `xfer_req` is high and `xfer_done` has not been seen, `xfer_req`, `xfer_word` and `xfer_rd` hold their values.
- R10: An `xfer_err` on any of the three ID transfers stops the run: `fail` rises, no further transfers are requested, `ready` stays 0 and `panel_rst_n` stays 1.
- R11: An `xfer_err` on a script, display-on or wake transfer adds one to `err_count`, which saturates at its maximum, and the run still completes with `ready`.
- R12: `start` at any time, including mid-run or after completion, restarts from the reset waveform. On the next cycle `ready`, `fail` and `err_count` are 0 and `panel_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the power-up run |
| panel_rst_n | output | 1 | Panel reset line (0 asserts reset) |
| xfer_req | output | 1 | Transfer request to the serial engine, held until done |
| xfer_rd | output | 1 | Request is a read |
| xfer_word | output | 9 | Bit 8 data/command flag, bits 7:0 byte |
| xfer_done | input | 1 | One-cycle completion from the engine |
| xfer_err | input | 1 | Error qualifier of `xfer_done` |
| xfer_rdata | input | ID_W | Read data qualified by `xfer_done` |
| ready | output | 1 | Sequence completed |
| fail | output | 1 | ID read failed, run aborted |
| err_count | output | ERR_W | Saturating count of script transfer errors |

## Verification
The embedded assertions check on every cycle the properties that hold at all times. The engine handshake holds its request. No request appears while the panel is held in reset. A failed run stays silent. `ready` and `fail` are never both set. The error count never drops except on `start`. Inside the timer, each millisecond count steps correctly. Only the bench's runs can show what a whole sequence produces. Those runs cover the exact length of each reset interval, the command and parameter stream of each script with its ID-based choice, the measured gaps after delayed entries, error saturation, abort at each ID transfer, and restart in the middle of a script.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

  localparam int ROM_AW = 6;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h04;
  localparam logic [BYTE_W-1:0] OP_DISP_ON = 8'h29;
  localparam logic [BYTE_W-1:0] OP_WAKE    = 8'h11;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_PARAM = 2'd1,
    K_WAIT  = 2'd2,
    K_END   = 2'd3
  } step_kind_t;

  typedef struct packed {
    step_kind_t        kind;
    logic [BYTE_W-1:0] val;
  } step_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RH1, S_RLO, S_RH2, S_IDDUM, S_IDGET, S_IDCHK, S_FETCH,
    S_EXEC, S_ADV, S_XFER, S_WAIT, S_DON, S_SLP, S_DONE, S_FAIL
  } seq_state_t;

  function automatic step_t mk(step_kind_t k, logic [BYTE_W-1:0] v);
    step_t s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  // Script A: entries with parameter bytes, two pause steps.
  function automatic step_t script_a(logic [ROM_AW-1:0] i);
    case (i)
      6'd0:  return mk(K_CMD,   8'h36);
      6'd1:  return mk(K_PARAM, 8'h08);
      6'd2:  return mk(K_CMD,   8'h3A);
      6'd3:  return mk(K_PARAM, 8'h66);
      6'd4:  return mk(K_CMD,   8'hB6);
      6'd5:  return mk(K_PARAM, 8'h22);
      6'd6:  return mk(K_PARAM, 8'hE2);
      6'd7:  return mk(K_PARAM, 8'hFF);
      6'd8:  return mk(K_PARAM, 8'h04);
      6'd9:  return mk(K_CMD,   8'hC5);
      6'd10: return mk(K_PARAM, 8'h00);
      6'd11: return mk(K_PARAM, 8'h6A);
      6'd12: return mk(K_CMD,   8'hE0);
      6'd13: return mk(K_PARAM, 8'h00);
      6'd14: return mk(K_PARAM, 8'h07);
      6'd15: return mk(K_PARAM, 8'h0D);
      6'd16: return mk(K_PARAM, 8'h10);
      6'd17: return mk(K_PARAM, 8'h13);
      6'd18: return mk(K_PARAM, 8'h19);
      6'd19: return mk(K_PARAM, 8'h0F);
      6'd20: return mk(K_PARAM, 8'h0C);
      6'd21: return mk(K_PARAM, 8'h05);
      6'd22: return mk(K_PARAM, 8'h08);
      6'd23: return mk(K_PARAM, 8'h06);
      6'd24: return mk(K_PARAM, 8'h13);
      6'd25: return mk(K_PARAM, 8'h0F);
      6'd26: return mk(K_PARAM, 8'h30);
      6'd27: return mk(K_PARAM, 8'h20);
      6'd28: return mk(K_PARAM, 8'h1F);
      6'd29: return mk(K_CMD,   8'hE1);
      6'd30: return mk(K_PARAM, 8'h1F);
      6'd31: return mk(K_PARAM, 8'h20);
      6'd32: return mk(K_PARAM, 8'h30);
      6'd33: return mk(K_PARAM, 8'h0F);
      6'd34: return mk(K_PARAM, 8'h13);
      6'd35: return mk(K_PARAM, 8'h06);
      6'd36: return mk(K_PARAM, 8'h08);
      6'd37: return mk(K_PARAM, 8'h05);
      6'd38: return mk(K_PARAM, 8'h0C);
      6'd39: return mk(K_PARAM, 8'h0F);
      6'd40: return mk(K_PARAM, 8'h19);
      6'd41: return mk(K_PARAM, 8'h13);
      6'd42: return mk(K_PARAM, 8'h10);
      6'd43: return mk(K_PARAM, 8'h0D);
      6'd44: return mk(K_PARAM, 8'h07);
      6'd45: return mk(K_PARAM, 8'h00);
      6'd46: return mk(K_WAIT,  8'd20);
      6'd47: return mk(K_CMD,   8'hB0);
      6'd48: return mk(K_PARAM, 8'h01);
      6'd49: return mk(K_CMD,   8'hB4);
      6'd50: return mk(K_PARAM, 8'h02);
      6'd51: return mk(K_WAIT,  8'd100);
      default: return mk(K_END, 8'h00);
    endcase
  endfunction

  // Script B: compact extended-command script.
  function automatic step_t script_b(logic [ROM_AW-1:0] i);
    case (i)
      6'd0:  return mk(K_CMD,   8'hFF);
      6'd1:  return mk(K_PARAM, 8'hFF);
      6'd2:  return mk(K_PARAM, 8'h98);
      6'd3:  return mk(K_PARAM, 8'h06);
      6'd4:  return mk(K_CMD,   8'hBA);
      6'd5:  return mk(K_PARAM, 8'h60);
      6'd6:  return mk(K_CMD,   8'h36);
      6'd7:  return mk(K_PARAM, 8'h00);
      6'd8:  return mk(K_CMD,   8'h3A);
      6'd9:  return mk(K_PARAM, 8'h66);
      6'd10: return mk(K_CMD,   8'h35);
      6'd11: return mk(K_PARAM, 8'h00);
      default: return mk(K_END, 8'h00);
    endcase
  endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CYCLES_PER_MS = 100000,
  parameter int MS_W          = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            busy
);

  localparam int PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYCLES_PER_MS - 1);

  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      rem  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      pre  <= PRE_TOP;
      rem  <= ms;
      busy <= (ms != '0);
    end else if (busy) begin
      if (pre == '0) begin
        pre <= PRE_TOP;
        rem <= rem - 1'b1;
        if (rem == MS_W'(1)) busy <= 1'b0;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  AST_MS_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && !load && pre != '0 |=> busy && rem == $past(rem)); // R2

  AST_MS_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(load) |-> $past(rem) == MS_W'(1) && $past(pre) == '0); // R7

endmodule

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
  import lcd_boot_pkg::*;
(
  input  logic              clk,
  input  logic              sel_first,
  input  logic [ROM_AW-1:0] addr,
  output step_t             q
);

  // Registered read so the two scripts map onto a synchronous ROM.
  always_ff @(posedge clk) begin
    q <= sel_first ? script_a(addr) : script_b(addr);
  end

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
  import lcd_boot_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int ID_W          = 8,
  parameter logic [ID_W-1:0] ID_FIRST = ID_W'(8'h80),
  parameter int ERR_W         = 8,
  parameter int RST_HI_MS     = 100,
  parameter int RST_LO_MS     = 40,
  parameter int SETTLE_MS     = 100,
  parameter int DISP_WAIT_MS  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              panel_rst_n,
  output logic              xfer_req,
  output logic              xfer_rd,
  output logic [WORD_W-1:0] xfer_word,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic [ID_W-1:0]   xfer_rdata,
  output logic              ready,
  output logic              fail,
  output logic [ERR_W-1:0]  err_count
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  seq_state_t state, state_n, ret, ret_n;
  logic [ROM_AW-1:0] ptr;
  logic [ID_W-1:0]   id_q;
  logic              sel_first;
  step_t             rom_q;

  logic              tmr_load, tmr_busy;
  logic [BYTE_W-1:0] tmr_ms;
  logic              iss, iss_rd;
  logic [WORD_W-1:0] iss_word;
  logic              ptr_inc, cap_sel, set_fail, err_inc, set_ready, line_n;
  logic              in_id;

  lcd_ms_timer #(.CYCLES_PER_MS(CYCLES_PER_MS), .MS_W(BYTE_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .ms(tmr_ms), .busy(tmr_busy)
  );

  lcd_script_rom u_rom (
    .clk(clk), .sel_first(sel_first), .addr(ptr), .q(rom_q)
  );

  assign in_id = (ret == S_IDDUM) || (ret == S_IDGET) || (ret == S_IDCHK);

  always_comb begin
    state_n   = state;
    ret_n     = ret;
    tmr_load  = 1'b0;
    tmr_ms    = '0;
    iss       = 1'b0;
    iss_rd    = 1'b0;
    iss_word  = '0;
    ptr_inc   = 1'b0;
    cap_sel   = 1'b0;
    set_fail  = 1'b0;
    err_inc   = 1'b0;
    set_ready = 1'b0;
    line_n    = panel_rst_n;
    if (start) begin
      state_n  = S_RH1;
      tmr_load = 1'b1;
      tmr_ms   = BYTE_W'(RST_HI_MS);
      line_n   = 1'b1;
    end else begin
      case (state)
        S_RH1: if (!tmr_busy) begin
          state_n  = S_RLO;
          tmr_load = 1'b1;
          tmr_ms   = BYTE_W'(RST_LO_MS);
          line_n   = 1'b0;
        end
        S_RLO: if (!tmr_busy) begin
          state_n  = S_RH2;
          tmr_load = 1'b1;
          tmr_ms   = BYTE_W'(SETTLE_MS);
          line_n   = 1'b1;
        end
        S_RH2: if (!tmr_busy) begin
          iss      = 1'b1;
          iss_word = {1'b0, OP_READ_ID};
          ret_n    = S_IDDUM;
        end
        S_IDDUM: begin
          iss    = 1'b1;
          iss_rd = 1'b1;
          ret_n  = S_IDGET;
        end
        S_IDGET: begin
          iss    = 1'b1;
          iss_rd = 1'b1;
          ret_n  = S_IDCHK;
        end
        S_IDCHK: begin
          cap_sel = 1'b1;
          state_n = S_FETCH;
        end
        S_FETCH: state_n = S_EXEC;
        S_EXEC: begin
          case (rom_q.kind)
            K_CMD: begin
              iss      = 1'b1;
              iss_word = {1'b0, rom_q.val};
              ret_n    = S_ADV;
            end
            K_PARAM: begin
              iss      = 1'b1;
              iss_word = {1'b1, rom_q.val};
              ret_n    = S_ADV;
            end
            K_WAIT: begin
              tmr_load = 1'b1;
              tmr_ms   = rom_q.val;
              state_n  = S_WAIT;
              ret_n    = S_ADV;
            end
            default: begin
              iss      = 1'b1;
              iss_word = {1'b0, OP_DISP_ON};
              ret_n    = S_DON;
            end
          endcase
        end
        S_ADV: begin
          ptr_inc = 1'b1;
          state_n = S_FETCH;
        end
        S_XFER: if (xfer_done) begin
          state_n = ret;
          if (xfer_err) begin
            if (in_id) begin
              set_fail = 1'b1;
              state_n  = S_FAIL;
            end else begin
              err_inc = 1'b1;
            end
          end
        end
        S_WAIT: if (!tmr_busy) state_n = ret;
        S_DON: begin
          tmr_load = 1'b1;
          tmr_ms   = BYTE_W'(DISP_WAIT_MS);
          state_n  = S_WAIT;
          ret_n    = S_SLP;
        end
        S_SLP: begin
          iss      = 1'b1;
          iss_word = {1'b0, OP_WAKE};
          ret_n    = S_DONE;
        end
        S_DONE: set_ready = 1'b1;
        default: ;
      endcase
      if (iss) state_n = S_XFER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ret         <= S_IDLE;
      panel_rst_n <= 1'b0;
      xfer_req    <= 1'b0;
      xfer_rd     <= 1'b0;
      xfer_word   <= '0;
      ptr         <= '0;
      id_q        <= '0;
      sel_first   <= 1'b0;
      err_count   <= '0;
      ready       <= 1'b0;
      fail        <= 1'b0;
    end else begin
      state       <= state_n;
      ret         <= ret_n;
      panel_rst_n <= line_n;
      if (start) begin
        xfer_req  <= 1'b0;
        ptr       <= '0;
        err_count <= '0;
        ready     <= 1'b0;
        fail      <= 1'b0;
      end else begin
        if (iss) begin
          xfer_req  <= 1'b1;
          xfer_word <= iss_word;
          xfer_rd   <= iss_rd;
        end else if (state == S_XFER && xfer_done) begin
          xfer_req <= 1'b0;
        end
        if (state == S_XFER && xfer_done && xfer_rd) id_q <= xfer_rdata;
        if (cap_sel) begin
          sel_first <= (id_q == ID_FIRST);
          ptr       <= '0;
        end
        if (ptr_inc) ptr <= ptr + 1'b1;
        if (err_inc && err_count != ERR_MAX) err_count <= err_count + 1'b1;
        if (set_fail) fail <= 1'b1;
        if (set_ready) ready <= 1'b1;
      end
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n |-> !xfer_req); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_done && !start |=> xfer_req && $stable(xfer_word) && $stable(xfer_rd)); // R9

  AST_READY_FAIL: assert property (@(posedge clk) disable iff (rst)
    ready |-> !fail); // R10

  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (rst)
    fail && !start |=> !xfer_req && fail); // R10

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready && !start |=> ready); // R8

  AST_ERR_MONO: assert property (@(posedge clk) disable iff (rst)
    !start |=> err_count >= $past(err_count)); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready && !fail && err_count == '0 && panel_rst_n); // R12

endmodule

// File: tb/lcd_boot_seq_test.sv
`timescale 1ns/1ps
module lcd_boot_seq_test;

  localparam int C = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       panel_rst_n, xfer_req, xfer_rd, ready, fail;
  logic [8:0] xfer_word;
  logic       xfer_done = 1'b0, xfer_err = 1'b0;
  logic [7:0] xfer_rdata = 8'h00;
  logic [1:0] err_count;

  int checks = 0, errors = 0, cyc = 0;
  int log_n = 0, rd_cnt = 0, hs_bad = 0;
  logic [8:0] log_word [128];
  logic       log_rd   [128];
  int         log_start[128];
  int         log_end  [128];
  logic [7:0]   id_val = 8'h80;
  logic [127:0] err_sel = '0;

  lcd_boot_seq #(.CYCLES_PER_MS(C), .ERR_W(2)) uut (
    .clk(clk), .rst(rst), .start(start), .panel_rst_n(panel_rst_n),
    .xfer_req(xfer_req), .xfer_rd(xfer_rd), .xfer_word(xfer_word),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata),
    .ready(ready), .fail(fail), .err_count(err_count)
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Serial engine model: variable latency, logs every completed transfer.
  initial begin
    bit pend = 0;
    int lat = 0, st = 0;
    logic [8:0] cw = '0;
    logic cr = 0;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
      if (pend) begin
        if (!xfer_req) pend = 0;
        else begin
          if (xfer_word != cw || xfer_rd != cr) hs_bad++;
          if (lat == 0) begin
            xfer_done  = 1'b1;
            xfer_err   = err_sel[log_n];
            xfer_rdata = cr ? ((rd_cnt == 0) ? 8'hA5 : id_val) : 8'h00;
            if (cr) rd_cnt++;
            log_word[log_n]  = cw;
            log_rd[log_n]    = cr;
            log_start[log_n] = st;
            log_end[log_n]   = cyc;
            log_n++;
            pend = 0;
          end else lat--;
        end
      end else if (xfer_req) begin
        pend = 1;
        cw   = xfer_word;
        cr   = xfer_rd;
        st   = cyc;
        lat  = 1 + (log_n % 3);
      end
    end
  end

  task automatic run(input logic [7:0] id, input logic [127:0] esel,
                     output int th1, output int tlo, output int th2);
    int t0, tf, tr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; t0 = cyc;
    check(panel_rst_n == 1'b1 && !ready && !fail && err_count == 2'd0,
          "R12 start clears", {ready, fail, err_count}, 0);
    @(negedge clk);
    log_n = 0; rd_cnt = 0; id_val = id; err_sel = esel;
    tf = t0; tr = t0;
    for (int i = 0; i < 20000 && panel_rst_n; i++) begin @(negedge clk); tf = cyc; end
    for (int i = 0; i < 20000 && !panel_rst_n; i++) begin @(negedge clk); tr = cyc; end
    for (int i = 0; i < 20000 && log_n == 0; i++) @(negedge clk);
    th1 = tf - t0; tlo = tr - tf; th2 = log_start[0] - tr;
    for (int i = 0; i < 40000 && !ready && !fail; i++) @(negedge clk);
  endtask

  task automatic verify(input bit first);
    logic [7:0] cmd[8];
    int cnt[8], dly[8], n, p, q, k, gap;
    if (first) begin
      cmd = '{8'h36, 8'h3A, 8'hB6, 8'hC5, 8'hE0, 8'hE1, 8'hB0, 8'hB4};
      cnt = '{1, 1, 4, 2, 16, 16, 1, 1};
      dly = '{0, 0, 0, 0, 0, 20, 0, 100};
      n = 8;
    end else begin
      cmd = '{8'hFF, 8'hBA, 8'h36, 8'h3A, 8'h35, 8'h00, 8'h00, 8'h00};
      cnt = '{3, 1, 1, 1, 1, 0, 0, 0};
      dly = '{0, 0, 0, 0, 0, 0, 0, 0};
      n = 5;
    end
    check(log_word[0] == 9'h004 && !log_rd[0], "R3 id command", log_word[0], 9'h004);
    check(log_rd[1] && log_rd[2], "R3 two reads", {log_rd[1], log_rd[2]}, 3);
    if (first) check(log_word[4] == 9'h108, "R6 param word", log_word[4], 9'h108);
    else check(log_word[4] == 9'h1FF && log_word[5] == 9'h198 && log_word[6] == 9'h106,
               "R5 ext params", log_word[6], 9'h106);
    p = 3;
    for (int e = 0; e < n; e++) begin
      check(log_word[p] == {1'b0, cmd[e]} && !log_rd[p],
            first ? "R4 command" : "R5 command", log_word[p], {1'b0, cmd[e]});
      k = 0; q = p + 1;
      while (q < log_n && log_word[q][8]) begin k++; q++; end
      check(k == cnt[e], "R6 param count", k, cnt[e]);
      gap = log_start[p + k + 1] - log_end[p + k];
      if (dly[e] == 0) check(gap <= 8, "R7 no pause", gap, 8);
      else check(gap >= dly[e] * C && gap <= dly[e] * C + 12, "R7 pause", gap, dly[e] * C);
      p = p + k + 1;
    end
    check(log_word[p] == 9'h029, "R8 display on", log_word[p], 9'h029);
    check(log_word[p + 1] == 9'h011, "R8 wake", log_word[p + 1], 9'h011);
    gap = log_start[p + 1] - log_end[p];
    check(gap >= 100 * C && gap <= 100 * C + 12, "R8 display pause", gap, 100 * C);
    check(log_n == p + 2 && ready && !fail, "R8 done", log_n, p + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h1, lo, h2;
    logic [7:0] sweep[6];
    sweep = '{8'h00, 8'h7F, 8'h80, 8'h81, 8'hC0, 8'hFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(!panel_rst_n && !xfer_req && !ready && !fail && err_count == 0,
          "R1 idle", {panel_rst_n, xfer_req, ready, fail}, 0);

    // Script A, clean run.
    run(8'h80, '0, h1, lo, h2);
    check(h1 == 100 * C + 1, "R2 first high", h1, 100 * C + 1);
    check(lo == 40 * C + 1, "R2 low", lo, 40 * C + 1);
    check(h2 == 100 * C + 1, "R2 settle", h2, 100 * C + 1);
    verify(1'b1);
    check(err_count == 0, "R11 no errors", err_count, 0);

    // Script B with two script errors: counted, run completes.
    run(8'h81, 128'h18, h1, lo, h2);
    verify(1'b0);
    check(err_count == 2, "R11 counted", err_count, 2);

    // Six errors on script A saturate the 2-bit counter.
    run(8'h80, 128'h1F8, h1, lo, h2);
    verify(1'b1);
    check(err_count == 3, "R11 saturate", err_count, 3);

    // Error on each ID transfer aborts.
    for (int j = 0; j < 3; j++) begin
      run(8'h80, 128'(1) << j, h1, lo, h2);
      repeat (200) @(negedge clk);
      check(fail && !ready && !xfer_req && panel_rst_n && log_n == j + 1,
            "R10 abort", log_n, j + 1);
    end

    // Restart in the middle of script A.
    run(8'h80, 128'h0, h1, lo, h2);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; log_n = 0; rd_cnt = 0; err_sel = 128'h38;
    for (int i = 0; i < 20000 && log_n < 8; i++) @(negedge clk);
    check(err_count == 3, "R11 mid errors", err_count, 3);
    run(8'h80, '0, h1, lo, h2);
    check(h1 == 100 * C + 1 && lo == 40 * C + 1, "R12 restart wave", h1, 100 * C + 1);
    verify(1'b1);

    // ID sweep: only the match value selects script A.
    foreach (sweep[s]) begin
      run(sweep[s], '0, h1, lo, h2);
      check(log_word[3] == ((sweep[s] == 8'h80) ? 9'h036 : 9'h0FF),
            (sweep[s] == 8'h80) ? "R4 select" : "R5 select", log_word[3],
            (sweep[s] == 8'h80) ? 9'h036 : 9'h0FF);
      check(ready, "R8 ready", ready, 1);
    end

    check(hs_bad == 0, "R9 handshake hold", hs_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule